// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This controller accepts a secret three-bit code one bit at a time. The operator restarts the lock, sets a key switch to the first code bit and presses an enter button. The operator repeats this for the second and third bits. Each entered bit is compared with the matching bit of a combination register. The combination register is written through a load strobe, and only while the lock is idle at its start state. When all three bits agree, the lock raises its open output. If any bit disagrees, it raises its alarm output, but only after the third bit has been entered. The alarm therefore never reveals which position was wrong.

The enter button arrives as a level, and only its rising edge counts as a press. The machine is a Moore machine with twelve states. The states are named in the table below, where "press" means a rising edge on `enter_lvl`. A high `restart` forces `S_START` from every state and takes priority over every other transition.

| State | Meaning | Next state |
|---|---|---|
| S_START | idle, ready | press -> S_CHK0, else stay |
| S_CHK0 | compare first bit | match -> S_WAIT0, mismatch -> S_XWAIT0 |
| S_WAIT0 | await second press | press -> S_CHK1, else stay |
| S_CHK1 | compare second bit | match -> S_WAIT1, mismatch -> S_XWAIT1 |
| S_WAIT1 | await third press | press -> S_CHK2, else stay |
| S_CHK2 | compare third bit | match -> S_OPEN, mismatch -> S_ALARM |
| S_OPEN | unlocked (open_o = 1) | stay |
| S_XWAIT0 | failed, await second press | press -> S_XCHK1, else stay |
| S_XCHK1 | failed, second bit not compared | always -> S_XWAIT1 |
| S_XWAIT1 | failed, await third press | press -> S_XCHK2, else stay |
| S_XCHK2 | failed, third bit not compared | always -> S_ALARM |
| S_ALARM | rejected (alarm_o = 1) | stay |

Top module: `serial_combo_lock`

## Requirements
- R1: After `rst_n` is deasserted, both outputs are low, the machine is in S_START, and the combination register holds the parameter INIT_CODE.
- R2: While `restart` is high at a clock edge, the machine enters S_START, and both outputs are low from the next cycle on. This applies from any state, including mid-sequence and the two terminal states.
- R3: Only a rising edge of `enter_lvl` counts as a press. Holding the level high for many cycles counts once. With no new edge, the machine stays in S_START or the current wait state.
- R4: `key_bit` is compared with combination bit 0 on the first press, bit 1 on the second press and bit 2 on the third press. The value of `key_bit` is taken in the cycle after the press. If all three bits match, `open_o` goes high.
- R5: Both outputs stay low until the third press has been evaluated. A mismatch in any position then raises `alarm_o`.
- R6: After a mismatch, later key bits are not compared. A sequence whose first bit is wrong ends in `alarm_o` even if the later bits are right.
- R7: `open_o` and `alarm_o` are never high together. Each holds, regardless of `enter_lvl` and `key_bit`, until `restart` is raised.
- R8: A high `code_load` in S_START writes `code_in` into the combination register at that clock edge.
- R9: A high `code_load` in any state other than S_START leaves the combination register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge active |
| rst_n | input | 1 | asynchronous chip reset, active low |
| restart | input | 1 | synchronous operator restart to S_START |
| enter_lvl | input | 1 | enter button level; the rising edge is a press |
| key_bit | input | 1 | key switch bit being entered |
| code_load | input | 1 | combination write strobe, honoured only in S_START |
| code_in | input | 3 | new combination, bit i checked at press i+1 |
| open_o | output | 1 | Moore output, high in S_OPEN |
| alarm_o | output | 1 | Moore output, high in S_ALARM |

## Verification
The bench builds the lock with INIT_CODE set to 3'b110 instead of the all-zero default. A reset-state defect in the combination register then shows up as a rejected code rather than passing unnoticed. The vector table covers a wrong bit in each position and in all positions, next to several matching codes. The directed tests cover a held enter level, restarts mid-sequence and in terminal states, and a load attempted in a wait state.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int CODE_W  = 3;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        S_START  = 4'd0,
        S_CHK0   = 4'd1,
        S_WAIT0  = 4'd2,
        S_CHK1   = 4'd3,
        S_WAIT1  = 4'd4,
        S_CHK2   = 4'd5,
        S_OPEN   = 4'd6,
        S_XWAIT0 = 4'd7,
        S_XCHK1  = 4'd8,
        S_XWAIT1 = 4'd9,
        S_XCHK2  = 4'd10,
        S_ALARM  = 4'd11
    } lock_state_e;

endpackage

// File: rtl/lock_enter_edge.sv
module lock_enter_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);

    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_i;
        end
    end

    // One-cycle strobe on the low-to-high transition of the level.
    assign pulse_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/lock_code_reg.sv
module lock_code_reg
    import lock_pkg::*;
#(
    parameter logic [CODE_W-1:0] INIT_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              allow_i,
    input  logic [CODE_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic wr_en;

    assign wr_en = load_i & allow_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= INIT_CODE;
        end else if (wr_en) begin
            code_o <= data_i;
        end
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              press_i,
    input  logic              key_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              at_start_o,
    output logic              open_o,
    output logic              alarm_o
);

    lock_state_e state_q;
    lock_state_e state_d;
    logic [CODE_W-1:0] hit;

    // Per-position agreement between the key switch and the stored code.
    for (genvar i = 0; i < CODE_W; i++) begin : g_hit
        assign hit[i] = ~(key_i ^ code_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_START;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = S_START;
        end else begin
            unique case (state_q)
                S_START:  if (press_i) state_d = S_CHK0;
                S_CHK0:   state_d = hit[0] ? S_WAIT0 : S_XWAIT0;
                S_WAIT0:  if (press_i) state_d = S_CHK1;
                S_CHK1:   state_d = hit[1] ? S_WAIT1 : S_XWAIT1;
                S_WAIT1:  if (press_i) state_d = S_CHK2;
                S_CHK2:   state_d = hit[2] ? S_OPEN : S_ALARM;
                S_OPEN:   state_d = S_OPEN;
                S_XWAIT0: if (press_i) state_d = S_XCHK1;
                S_XCHK1:  state_d = S_XWAIT1;
                S_XWAIT1: if (press_i) state_d = S_XCHK2;
                S_XCHK2:  state_d = S_ALARM;
                S_ALARM:  state_d = S_ALARM;
                default:  state_d = S_START;
            endcase
        end
    end

    // Moore outputs decoded from the current state only.
    always_comb begin
        at_start_o = 1'b0;
        open_o     = 1'b0;
        alarm_o    = 1'b0;
        unique case (state_q)
            S_START: at_start_o = 1'b1;
            S_OPEN:  open_o     = 1'b1;
            S_ALARM: alarm_o    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/serial_combo_lock.sv
module serial_combo_lock
    import lock_pkg::*;
#(
    parameter logic [2:0] INIT_CODE = 3'b000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       enter_lvl,
    input  logic       key_bit,
    input  logic       code_load,
    input  logic [2:0] code_in,
    output logic       open_o,
    output logic       alarm_o
);

    logic              press;
    logic              at_start;
    logic [CODE_W-1:0] code_q;

    lock_enter_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (enter_lvl),
        .pulse_o (press)
    );

    lock_code_reg #(
        .INIT_CODE (INIT_CODE)
    ) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (code_load),
        .allow_i (at_start),
        .data_i  (code_in),
        .code_o  (code_q)
    );

    lock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .press_i    (press),
        .key_i      (key_bit),
        .code_i     (code_q),
        .at_start_o (at_start),
        .open_o     (open_o),
        .alarm_o    (alarm_o)
    );

endmodule

// File: rtl/lock_checker.sv
module lock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       enter_lvl,
    input logic       code_load,
    input logic [2:0] code_in,
    input logic [2:0] code_q,
    input logic       at_start,
    input logic       open_o,
    input logic       alarm_o
);

    logic       lvl_prev;
    logic [1:0] edges;

    // Saturating count of enter edges since the last restart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
            edges    <= 2'd0;
        end else begin
            lvl_prev <= enter_lvl;
            if (restart) begin
                edges <= 2'd0;
            end else if (enter_lvl && !lvl_prev && edges != 2'd3) begin
                edges <= edges + 2'd1;
            end
        end
    end

    p_mutex_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_o && alarm_o));

    p_open_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && !restart) |=> open_o);

    p_alarm_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !restart) |=> alarm_o);

    p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!open_o && !alarm_o));

    p_three_presses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o || alarm_o) |-> (edges == 2'd3));

    p_load_in_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_load && at_start) |=> (code_q == $past(code_in)));

    p_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_load && !at_start) |=> $stable(code_q));

endmodule

bind serial_combo_lock lock_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .enter_lvl (enter_lvl),
    .code_load (code_load),
    .code_in   (code_in),
    .code_q    (code_q),
    .at_start  (at_start),
    .open_o    (open_o),
    .alarm_o   (alarm_o)
);

// File: tb/test_serial_combo_lock.sv
`timescale 1ns/1ps
module test_serial_combo_lock;

    localparam logic [2:0] TB_INIT = 3'b110;
    localparam int NVEC = 8;
    // {code[2:0], keys entered bit0 first [2:0], expect open, expect alarm}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b101_101_10,
        8'b000_000_10,
        8'b111_111_10,
        8'b010_011_01,
        8'b010_000_01,
        8'b011_111_01,
        8'b100_011_01,
        8'b110_110_10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       enter_lvl = 1'b0;
    logic       key_bit = 1'b0;
    logic       code_load = 1'b0;
    logic [2:0] code_in = 3'b000;
    logic       open_o;
    logic       alarm_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_combo_lock #(.INIT_CODE(TB_INIT)) i_serial_combo_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .enter_lvl (enter_lvl),
        .key_bit   (key_bit),
        .code_load (code_load),
        .code_in   (code_in),
        .open_o    (open_o),
        .alarm_o   (alarm_o)
    );

    task automatic chk(input string req, input logic [1:0] exp);
        total++;
        if ({open_o, alarm_o} !== exp) begin
            bad++;
            $display("FAIL %s: {open,alarm} actual=%b expected=%b", req, {open_o, alarm_o}, exp);
        end
    endtask

    task automatic press_bit(input logic b);
        @(negedge clk);
        key_bit   = b;
        enter_lvl = 1'b1;
        @(negedge clk);
        enter_lvl = 1'b0;
        @(negedge clk);
    endtask

    task automatic press_code(input logic [2:0] k);
        for (int i = 0; i < 3; i++) press_bit(k[i]);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic do_load(input logic [2:0] v);
        @(negedge clk);
        code_load = 1'b1;
        code_in   = v;
        @(negedge clk);
        code_load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 2'b00);
        press_code(TB_INIT);
        chk("R1 reset code accepted", 2'b10);

        // Table walk: load, enter, compare.
        for (int v = 0; v < NVEC; v++) begin
            do_restart();
            chk("R2 restart clears", 2'b00);
            do_load(VEC[v][7:5]);
            press_bit(VEC[v][2]);
            press_bit(VEC[v][3]);
            chk("R5 no early output", 2'b00);
            press_bit(VEC[v][4]);
            if (VEC[v][1]) chk("R4 R8 matching code opens", VEC[v][1:0]);
            else           chk("R5 R6 wrong code alarms", VEC[v][1:0]);
        end

        // Held enter level counts once; idle without edges stays put.
        do_restart();
        do_load(3'b011);
        @(negedge clk);
        key_bit   = 1'b1;
        enter_lvl = 1'b1;
        repeat (6) @(negedge clk);
        enter_lvl = 1'b0;
        repeat (10) @(negedge clk);
        chk("R3 held enter counted once", 2'b00);
        press_bit(1'b1);
        press_bit(1'b0);
        chk("R3 sequence completes after held press", 2'b10);

        // Terminal hold: further presses do not change OPEN.
        press_code(3'b000);
        chk("R7 open holds", 2'b10);

        // First bit wrong, later bits right: still alarm; alarm holds.
        do_restart();
        press_code(3'b010);
        chk("R6 first mismatch ends in alarm", 2'b01);
        press_code(3'b011);
        chk("R7 alarm holds", 2'b01);

        // Restart mid-sequence then full correct code.
        do_restart();
        press_bit(1'b1);
        do_restart();
        chk("R2 restart mid sequence", 2'b00);
        press_code(3'b011);
        chk("R2 fresh sequence after restart", 2'b10);

        // Load outside START is ignored.
        do_restart();
        do_load(3'b001);
        press_bit(1'b1);
        do_load(3'b110);
        press_bit(1'b0);
        press_bit(1'b0);
        chk("R9 old code still opens", 2'b10);
        do_restart();
        press_code(3'b110);
        chk("R9 late load not stored", 2'b01);

        // Chip reset restores the initial combination.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after second reset", 2'b00);
        press_code(TB_INIT);
        chk("R1 initial code restored", 2'b10);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule